// File: doc/BRIEF.md
# Dual Static/Rate-of-Change Alarm Monitor

This block runs two independent alarm channels. On every sample strobe, each channel takes a value from one of three data sources. It then tests either the value itself (static mode) or the change since an earlier sample (rate-of-change mode) against a signed threshold, in the direction its configuration selects. When the test is true, the channel sets a sticky flag. The flags are cleared by a status-read strobe. If the condition still holds, they set again at the next sample.

The two flags are combined into one alarm indication. That indication can be routed, with a chosen polarity, to one of two general-purpose I/O lines. A data-ready indicator assigned to a line always takes that line over. The data sources are computed outside this block. Configuration arrives as static inputs from the owning register file.

Top module: `dual_alarm_monitor`

## Requirements
- R1: Source code 1 selects the rate word, 2 the temperature word and 3 the status word. Code 0 and codes 4 to 15 disable the channel, and a disabled channel never sets its flag.
- R2: In static mode (mode bit 0), the flag sets when the signed value is strictly greater than the signed threshold (direction bit 1) or strictly less than it (direction bit 0).
- R3: In rate-of-change mode (mode bit 1), the signed difference between the current value and the value S samples earlier is compared, without wrap, against the threshold in the selected direction. S is 8 bits, and S = 0 and S = 1 both mean one sample back.
- R4: After reset, or after any change to a channel's source code, mode bit, S or the filter bit, a rate-of-change channel raises no alarm until S samples have been stored. A sample strobe in the same cycle as a change counts as the first stored sample.
- R5: With the filter bit at 1, source 1 uses the filtered rate input instead of the raw rate input. Sources 2 and 3 are unaffected by the filter bit.
- R6: flag_o[0] belongs to alarm 1 and flag_o[1] to alarm 2. A flag goes high in the cycle after a sample strobe whose condition is true. It holds while no read and no sample occur.
- R7: A status-read strobe clears both flags on the next edge. A true condition on a sample strobe in the same cycle keeps its flag set.
- R8: With the pin enabled, the selected line (0 = line 0, 1 = line 1) is driven with the OR of both flags: high-true when the polarity bit is 1 and inverted when it is 0.
- R9: A line whose data-ready enable bit is 1 is driven with drdy_i, whatever the alarm pin settings are.
- R10: A line claimed by neither data-ready nor an enabled alarm pin has output enable 0 and output 0.
- R11: Each channel keeps its own history and collection count, so the two channels can use different S values and sources at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe, one cycle per sample |
| rate_raw_i | input | DATA_W | Unfiltered rate word |
| rate_filt_i | input | DATA_W | Filtered rate word |
| temp_i | input | DATA_W | Temperature word |
| stat_word_i | input | DATA_W | Status word used as a source |
| src_sel_i | input | 2x4 | Source code per channel |
| roc_en_i | input | 2 | Mode per channel, 1 = rate of change |
| above_i | input | 2 | Direction per channel, 1 = above |
| filt_en_i | input | 1 | Use the filtered rate for source 1 |
| thresh_i | input | 2xDATA_W | Signed threshold per channel |
| span_i | input | 2xSPAN_W | Sample distance S per channel |
| pin_en_i | input | 1 | Alarm pin enable |
| pin_pol_i | input | 1 | Alarm pin polarity, 1 = active high |
| pin_sel_i | input | 1 | Alarm line select |
| drdy_i | input | 1 | Data-ready level |
| drdy_line_en_i | input | 2 | Data-ready assignment per line |
| stat_rd_i | input | 1 | Status-read strobe |
| flag_o | output | 2 | Sticky alarm flags |
| line_o | output | 2 | Line output values |
| line_oe_o | output | 2 | Line output enables |

## Verification
The assertions check on every cycle that the flags hold between events, clear on a read, and never rise on a disabled source. They also check the line ownership rules: data-ready priority, the level of the routed alarm pin, and idle lines left undriven. Only the bench scenarios show the threshold arithmetic, the signed history difference at each S, the warm-up after a configuration change and the filtered-source selection. These depend on the sample history, and the bench follows that history with an independent shift-array model.

// File: rtl/alarm_mon_pkg.sv
package alarm_mon_pkg;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned SRC_W     = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF  = 4'd0,
    SRC_RATE = 4'd1,
    SRC_TEMP = 4'd2,
    SRC_STAT = 4'd3
  } src_e;
endpackage

// File: rtl/alarm_src_mux.sv
module alarm_src_mux
  import alarm_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [SRC_W-1:0]  sel_i,
  input  logic              filt_en_i,
  input  logic [DATA_W-1:0] rate_raw_i,
  input  logic [DATA_W-1:0] rate_filt_i,
  input  logic [DATA_W-1:0] temp_i,
  input  logic [DATA_W-1:0] stat_word_i,
  output logic [DATA_W-1:0] val_o,
  output logic              active_o
);
  always_comb begin
    active_o = 1'b1;
    val_o    = '0;
    case (sel_i)
      SRC_RATE: val_o = filt_en_i ? rate_filt_i : rate_raw_i;
      SRC_TEMP: val_o = temp_i;
      SRC_STAT: val_o = stat_word_i;
      default:  active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alarm_history.sv
module alarm_history #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SPAN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SPAN_W-1:0] span_i,
  output logic [DATA_W-1:0] old_o,
  output logic              ready_o
);
  localparam int unsigned DEPTH = (1 << SPAN_W) - 1;
  localparam logic [SPAN_W-1:0] LAST = SPAN_W'(DEPTH - 1);
  localparam logic [SPAN_W-1:0] FULL = SPAN_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [SPAN_W-1:0] wr_q, fill_q, fill_eff, back, rd_idx;

  // span 0 behaves as 1
  assign back     = (span_i == '0) ? SPAN_W'(1) : span_i;
  assign fill_eff = restart_i ? '0 : fill_q;
  assign ready_o  = fill_eff >= back;
  // modulo-DEPTH subtract: wrapping past zero costs one extra slot
  assign rd_idx   = wr_q - back - SPAN_W'(wr_q < back);
  assign old_o    = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      wr_q   <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      fill_q <= (fill_eff == FULL) ? fill_eff : fill_eff + 1'b1;
    end else begin
      fill_q <= fill_eff;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              active_i,
  input  logic              roc_i,
  input  logic              above_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic              hit_o
);
  logic signed [DATA_W:0] cur_x, old_x, thr_x, diff, lhs;

  always_comb begin
    cur_x = $signed({cur_i[DATA_W-1], cur_i});
    old_x = $signed({old_i[DATA_W-1], old_i});
    thr_x = $signed({thr_i[DATA_W-1], thr_i});
    diff  = cur_x - old_x;
    lhs   = roc_i ? diff : cur_x;
    hit_o = active_i && (!roc_i || ready_i) && (above_i ? (lhs > thr_x) : (lhs < thr_x));
  end
endmodule

// File: rtl/alarm_line_drive.sv
module alarm_line_drive
  import alarm_mon_pkg::*;
(
  input  logic                 alarm_any_i,
  input  logic                 pin_en_i,
  input  logic                 pin_pol_i,
  input  logic                 pin_sel_i,
  input  logic                 drdy_i,
  input  logic [NUM_LINES-1:0] drdy_line_en_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic [NUM_LINES-1:0] line_oe_o
);
  logic level;
  assign level = pin_pol_i ? alarm_any_i : ~alarm_any_i;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    always_comb begin
      if (drdy_line_en_i[k]) begin
        line_oe_o[k] = 1'b1;
        line_o[k]    = drdy_i;
      end else if (pin_en_i && (pin_sel_i == 1'(k))) begin
        line_oe_o[k] = 1'b1;
        line_o[k]    = level;
      end else begin
        line_oe_o[k] = 1'b0;
        line_o[k]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_alarm_monitor.sv
module dual_alarm_monitor
  import alarm_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SPAN_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sample_i,
  input  logic [DATA_W-1:0]             rate_raw_i,
  input  logic [DATA_W-1:0]             rate_filt_i,
  input  logic [DATA_W-1:0]             temp_i,
  input  logic [DATA_W-1:0]             stat_word_i,
  input  logic [NUM_CH-1:0][SRC_W-1:0]  src_sel_i,
  input  logic [NUM_CH-1:0]             roc_en_i,
  input  logic [NUM_CH-1:0]             above_i,
  input  logic                          filt_en_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] thresh_i,
  input  logic [NUM_CH-1:0][SPAN_W-1:0] span_i,
  input  logic                          pin_en_i,
  input  logic                          pin_pol_i,
  input  logic                          pin_sel_i,
  input  logic                          drdy_i,
  input  logic [NUM_LINES-1:0]          drdy_line_en_i,
  input  logic                          stat_rd_i,
  output logic [NUM_CH-1:0]             flag_o,
  output logic [NUM_LINES-1:0]          line_o,
  output logic [NUM_LINES-1:0]          line_oe_o
);
  localparam int unsigned CFG_W = SRC_W + 2 + SPAN_W;

  logic [NUM_CH-1:0] flag_q, hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] cur, old;
    logic              active, ready, restart;
    logic [CFG_W-1:0]  cfg, cfg_q;

    assign cfg     = {src_sel_i[c], roc_en_i[c], filt_en_i, span_i[c]};
    assign restart = cfg != cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else         cfg_q <= cfg;
    end

    alarm_src_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i       (src_sel_i[c]),
      .filt_en_i   (filt_en_i),
      .rate_raw_i  (rate_raw_i),
      .rate_filt_i (rate_filt_i),
      .temp_i      (temp_i),
      .stat_word_i (stat_word_i),
      .val_o       (cur),
      .active_o    (active)
    );

    alarm_history #(.DATA_W(DATA_W), .SPAN_W(SPAN_W)) u_hist (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (sample_i),
      .restart_i (restart),
      .data_i    (cur),
      .span_i    (span_i[c]),
      .old_o     (old),
      .ready_o   (ready)
    );

    alarm_cmp #(.DATA_W(DATA_W)) u_cmp (
      .active_i (active),
      .roc_i    (roc_en_i[c]),
      .above_i  (above_i[c]),
      .ready_i  (ready),
      .cur_i    (cur),
      .old_i    (old),
      .thr_i    (thresh_i[c]),
      .hit_o    (hit[c])
    );
  end

  // set beats clear when a sample and a read coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~{NUM_CH{stat_rd_i}}) | ({NUM_CH{sample_i}} & hit);
  end

  assign flag_o = flag_q;

  alarm_line_drive u_drive (
    .alarm_any_i    (|flag_q),
    .pin_en_i       (pin_en_i),
    .pin_pol_i      (pin_pol_i),
    .pin_sel_i      (pin_sel_i),
    .drdy_i         (drdy_i),
    .drdy_line_en_i (drdy_line_en_i),
    .line_o         (line_o),
    .line_oe_o      (line_oe_o)
  );
endmodule

// File: rtl/dual_alarm_monitor_chk.sv
module dual_alarm_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sample_i,
  input logic       stat_rd_i,
  input logic [3:0] src0_i,
  input logic [3:0] src1_i,
  input logic       pin_en_i,
  input logic       pin_pol_i,
  input logic       pin_sel_i,
  input logic       drdy_i,
  input logic [1:0] drdy_line_en_i,
  input logic [1:0] flag_o,
  input logic [1:0] line_o,
  input logic [1:0] line_oe_o
);
  // R7
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !sample_i |=> flag_o == 2'b00);

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i && !stat_rd_i |=> $stable(flag_o));

  // R1
  off_src0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && (src0_i == 4'd0 || src0_i > 4'd3) |=> !flag_o[0]);

  // R1
  off_src1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && (src1_i == 4'd0 || src1_i > 4'd3) |=> !flag_o[1]);

  // R9
  drdy_line0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_line_en_i[0] |-> line_oe_o[0] && line_o[0] == drdy_i);

  // R9
  drdy_line1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_line_en_i[1] |-> line_oe_o[1] && line_o[1] == drdy_i);

  // R8
  alarm_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_en_i && !drdy_line_en_i[pin_sel_i] |->
      line_oe_o[pin_sel_i] && line_o[pin_sel_i] == (pin_pol_i ? |flag_o : ~|flag_o));

  // R10
  idle_line0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_line_en_i[0] && !(pin_en_i && !pin_sel_i) |-> !line_oe_o[0] && !line_o[0]);

  // R10
  idle_line1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_line_en_i[1] && !(pin_en_i && pin_sel_i) |-> !line_oe_o[1] && !line_o[1]);
endmodule

bind dual_alarm_monitor dual_alarm_monitor_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_i       (sample_i),
  .stat_rd_i      (stat_rd_i),
  .src0_i         (src_sel_i[0]),
  .src1_i         (src_sel_i[1]),
  .pin_en_i       (pin_en_i),
  .pin_pol_i      (pin_pol_i),
  .pin_sel_i      (pin_sel_i),
  .drdy_i         (drdy_i),
  .drdy_line_en_i (drdy_line_en_i),
  .flag_o         (flag_o),
  .line_o         (line_o),
  .line_oe_o      (line_oe_o)
);

// File: tb/dual_alarm_monitor_test.sv
`timescale 1ns/1ps
module dual_alarm_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample, filt_en, pin_en, pin_pol, pin_sel, drdy, stat_rd;
  logic [15:0] rate_raw, rate_filt, temp, stat_word;
  logic [1:0][3:0] src;
  logic [1:0] roc, above, drdy_en, flag, line, line_oe;
  logic [1:0][15:0] thr;
  logic [1:0][7:0] span;

  int nchk = 0;
  int nerr = 0;

  int mhist [2][256];
  int mfill [2];
  logic [13:0] mcfg [2];
  logic [1:0] mflag;

  always #2.5 clk = ~clk;

  dual_alarm_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .rate_raw_i(rate_raw), .rate_filt_i(rate_filt), .temp_i(temp), .stat_word_i(stat_word),
    .src_sel_i(src), .roc_en_i(roc), .above_i(above), .filt_en_i(filt_en),
    .thresh_i(thr), .span_i(span),
    .pin_en_i(pin_en), .pin_pol_i(pin_pol), .pin_sel_i(pin_sel),
    .drdy_i(drdy), .drdy_line_en_i(drdy_en), .stat_rd_i(stat_rd),
    .flag_o(flag), .line_o(line), .line_oe_o(line_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    sample = 0; filt_en = 0; pin_en = 0; pin_pol = 0; pin_sel = 0; drdy = 0; stat_rd = 0;
    rate_raw = 0; rate_filt = 0; temp = 0; stat_word = 0;
    src = '0; roc = '0; above = '0; drdy_en = '0; thr = '0; span = '0;
  endtask

  // one cycle: check lines on current state, predict flags, clock, check flags
  task automatic step(input string ftag, input string ltag);
    logic [1:0] nf;
    logic any;
    #1;
    any = |mflag;
    for (int k = 0; k < 2; k++) begin
      logic eo, ev;
      if (drdy_en[k]) begin eo = 1; ev = drdy; end
      else if (pin_en && pin_sel == k[0]) begin eo = 1; ev = pin_pol ? any : !any; end
      else begin eo = 0; ev = 0; end
      chk(ltag, {30'd0, line_oe[k], line[k]}, {30'd0, eo, ev});
    end
    nf = mflag & ~{2{stat_rd}};
    for (int ch = 0; ch < 2; ch++) begin
      logic [13:0] cfg;
      int val, back, diff, t;
      bit act, hit;
      cfg = {src[ch], roc[ch], filt_en, span[ch]};
      if (cfg != mcfg[ch]) mfill[ch] = 0;
      mcfg[ch] = cfg;
      back = (span[ch] == 0) ? 1 : int'(span[ch]);
      act = 1;
      case (src[ch])
        4'd1: val = filt_en ? int'($signed(rate_filt)) : int'($signed(rate_raw));
        4'd2: val = int'($signed(temp));
        4'd3: val = int'($signed(stat_word));
        default: begin act = 0; val = 0; end
      endcase
      t = int'($signed(thr[ch]));
      hit = 0;
      if (sample && act) begin
        if (roc[ch]) begin
          if (mfill[ch] >= back) begin
            diff = val - mhist[ch][back-1];
            hit = above[ch] ? (diff > t) : (diff < t);
          end
        end else begin
          hit = above[ch] ? (val > t) : (val < t);
        end
      end
      if (hit) nf[ch] = 1'b1;
      if (sample) begin
        for (int j = 255; j > 0; j--) mhist[ch][j] = mhist[ch][j-1];
        mhist[ch][0] = val;
        if (mfill[ch] < 255) mfill[ch]++;
      end
    end
    mflag = nf;
    @(posedge clk);
    @(negedge clk);
    chk(ftag, {30'd0, flag}, {30'd0, mflag});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_inputs();
    mflag = '0;
    for (int ch = 0; ch < 2; ch++) begin mfill[ch] = 0; mcfg[ch] = '0; end
    repeat (3) @(negedge clk);
    // reset state
    chk("R6 reset flags", {30'd0, flag}, 0);
    chk("R10 reset lines", {28'd0, line_oe, line}, 0);
    rst_n = 1;
    step("R6", "R10");

    // R2 static, temperature source, strict above
    src[0] = 4'd2; above[0] = 1; thr[0] = 16'd100;
    temp = 16'd100; sample = 1; step("R2 equal no hit", "R10");
    temp = 16'd101; step("R2 above hit", "R10");
    sample = 0; step("R6 hold", "R10");
    stat_rd = 1; step("R7 read clear", "R10");
    stat_rd = 0;
    above[0] = 0; thr[0] = 16'hFFFB; temp = 16'hFFFA; sample = 1; step("R2 below signed", "R10");
    stat_rd = 1; step("R7 read with hit stays", "R10");
    stat_rd = 1; sample = 0; step("R7", "R10");
    stat_rd = 0;

    // R5 filtered rate selection
    src[0] = 4'd1; above[0] = 1; thr[0] = 16'd1000; filt_en = 1;
    rate_raw = 16'd2000; rate_filt = 16'd0; sample = 1; step("R5 filtered quiet", "R10");
    filt_en = 0; step("R5 raw loud", "R10");
    stat_rd = 1; sample = 0; step("R7", "R10"); stat_rd = 0;

    // R1 disabled codes
    src[0] = 4'd7; src[1] = 4'd0; above = 2'b11; thr = '0; temp = 16'd50;
    stat_word = 16'd50; rate_raw = 16'd50; sample = 1;
    step("R1 code7", "R10"); step("R1 code0", "R10");

    // R3/R4 rate of change, S=3, status source on alarm 2
    src[1] = 4'd3; roc[1] = 1; span[1] = 8'd3; above[1] = 1; thr[1] = 16'd10;
    stat_word = 16'd0;  step("R4 warmup", "R10");
    stat_word = 16'd40; step("R4 warmup", "R10");
    stat_word = 16'd40; step("R4 warmup", "R10");
    stat_word = 16'd20; step("R3 diff3 hit", "R10");
    stat_rd = 1; sample = 0; step("R7", "R10"); stat_rd = 0; sample = 1;
    stat_word = 16'd45; step("R3 diff5 no hit", "R10");
    // extreme difference without wrap
    above[1] = 0; thr[1] = 16'h8000; span[1] = 8'd0;
    stat_word = 16'h7FFF; step("R4 restart", "R10");
    stat_word = 16'h8000; step("R3 span0 wide diff", "R10");
    stat_word = 16'h7FFF; above[1] = 1; thr[1] = 16'h7FFF; step("R3 wide positive", "R10");

    // R11 independent channels with different spans
    stat_rd = 1; sample = 0; step("R7", "R10"); stat_rd = 0;
    src[0] = 4'd2; roc[0] = 1; span[0] = 8'd1; above[0] = 1; thr[0] = 16'd5;
    src[1] = 4'd2; roc[1] = 1; span[1] = 8'd2; above[1] = 1; thr[1] = 16'd5;
    sample = 1;
    temp = 16'd0;  step("R11", "R10");
    temp = 16'd4;  step("R11", "R10");
    temp = 16'd8;  step("R11 span1 quiet span2 hit", "R10");

    // R8 pin routing, R9 data-ready priority
    pin_en = 1; pin_pol = 1; pin_sel = 1; sample = 0; step("R6", "R8 high true");
    pin_pol = 0; step("R6", "R8 inverted");
    pin_sel = 0; step("R6", "R8 line0");
    drdy_en = 2'b01; drdy = 1; step("R6", "R9 priority");
    drdy = 0; step("R6", "R9 priority low");
    drdy_en = 2'b10; pin_en = 0; step("R6", "R10 idle line0");

    // constrained random mix
    for (int it = 0; it < 6000; it++) begin
      if (it == 0 || $urandom_range(0, 599) == 0) begin
        for (int ch = 0; ch < 2; ch++) begin
          int pick;
          src[ch] = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
          roc[ch] = 1'($urandom_range(0, 1));
          pick = $urandom_range(0, 7);
          span[ch] = (pick == 7) ? 8'd255 : (pick == 6) ? 8'd16 : 8'(pick);
        end
        filt_en = 1'($urandom_range(0, 1));
      end
      for (int ch = 0; ch < 2; ch++) begin
        if ($urandom_range(0, 49) == 0) begin
          above[ch] = 1'($urandom_range(0, 1));
          thr[ch] = 16'($urandom_range(0, 120)) - 16'd60;
        end
      end
      if ($urandom_range(0, 3) == 0) begin
        rate_raw = 16'($urandom); rate_filt = 16'($urandom);
        temp = 16'($urandom); stat_word = 16'($urandom);
      end else begin
        rate_raw = 16'($urandom_range(0, 200)) - 16'd100;
        rate_filt = 16'($urandom_range(0, 200)) - 16'd100;
        temp = 16'($urandom_range(0, 200)) - 16'd100;
        stat_word = 16'($urandom_range(0, 200)) - 16'd100;
      end
      sample  = 1'($urandom_range(0, 1));
      stat_rd = ($urandom_range(0, 7) == 0);
      drdy    = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 31) == 0) begin
        drdy_en = 2'($urandom_range(0, 3));
        pin_en = 1'($urandom_range(0, 1));
        pin_pol = 1'($urandom_range(0, 1));
        pin_sel = 1'($urandom_range(0, 1));
      end
      step("R6 random", "R8 random");
    end
    finish_run();
  end
endmodule